// File: doc/BRIEF.md
# Polarity-Configurable Interrupt Controller

This block collects up to 32 interrupt request lines and presents them to a processor as two request outputs: a normal interrupt and a critical (machine-check class) interrupt. Every line can be set up on its own as active-high or active-low, and as level-sensitive or edge-sensitive. Each line is also steered to one of the two outputs. Raw events are latched into a status register. Software clears a status bit by writing a one to it, and that write is also the end-of-interrupt action for the source.

An enable register gates which latched events count. A read-only view returns status ANDed with enable. A fixed-priority encoder reports the lowest-numbered enabled pending source, so software can find the source to service without scanning bits. Every request line first passes through a two-flop synchronizer. Configuration and status are reached over a single-cycle register bus with combinational read data.

Top module: `irq_hub`

## Requirements
- R1: After reset, status, enable and trigger read 0x00000000, while routing and polarity read 0xFFFFFFFF. irq_o, crit_o and pend_valid_o are all low.
- R2: Source n (input bit n) owns register bit 31-n in every register. An active input shows in status on the third rising clock edge after it is applied.
- R3: A polarity bit of 1 makes the source active when its input is high, and 0 makes it active when its input is low. A source whose input sits at its inactive level never sets status.
- R4: With a trigger bit of 0 the source is level-sensitive. Status stays set while the input is active, so a clear issued while the input is still active leaves the bit reading 1.
- R5: With a trigger bit of 1 the source is edge-sensitive. Status sets only on the transition into the active level and stays set after the input is released. A clear issued while the input is still held active leaves the bit at 0.
- R6: Writing status (offset 0x00) clears every bit written as 1 and leaves bits written as 0 unchanged. If a new event and a clear of the same bit land in the same cycle, the bit stays set.
- R7: Offset 0x14 reads status AND enable. Writes to 0x14 change no register.
- R8: An enable bit of 0 keeps its source out of irq_o, crit_o and the pending index, but the source still latches into status.
- R9: A routing bit (offset 0x08) of 1 sends an enabled pending source to irq_o, and 0 sends it to crit_o. Each output is high while at least one enabled pending source is steered to it.
- R10: pend_idx_o gives the lowest-numbered source whose bit in status AND enable is set, and pend_valid_o is then high. With none set, pend_valid_o is low.
- R11: The register offsets are: status 0x00, enable 0x04, routing 0x08, polarity 0x0C, trigger 0x10, masked status 0x14. Reads of 0x18 and 0x1C return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| src_i | input | 32 | Request lines, bit n is source n |
| req_i | input | 1 | Bus access strobe |
| we_i | input | 1 | Write when high, read when low |
| addr_i | input | 5 | Byte address |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, combinational from addr_i |
| irq_o | output | 1 | Normal interrupt request |
| crit_o | output | 1 | Critical interrupt request |
| pend_valid_o | output | 1 | Some enabled source is pending |
| pend_idx_o | output | 5 | Highest-priority pending source |

## Verification
The bench sweeps every source through all four combinations of polarity and trigger mode. It checks the bit-reversed register position, latching after release, and the behaviour of a clear while the input is still active. A design that treated edge sources as level sources would fail that last case, because it would leave the bit set. The priority sweep moves the lowest pending source across all 32 positions with noise on the higher-numbered sources, then disables the winner. An encoder that scanned in the wrong direction would report the wrong index. The bench also lands a clear and a new edge in exactly the same cycle to catch a clear that wins over a new event. It also checks that a write to the masked view alters nothing, and that a source steered to critical never raises the normal output.

// File: rtl/irq_hub_pkg.sv
package irq_hub_pkg;
  localparam int unsigned WORD_W = 3;
  typedef enum logic [WORD_W-1:0] {
    W_STAT  = 3'd0,
    W_EN    = 3'd1,
    W_ROUTE = 3'd2,
    W_POL   = 3'd3,
    W_TRIG  = 3'd4,
    W_MASK  = 3'd5
  } reg_word_e;
endpackage

// File: rtl/irq_hub_sync.sv
module irq_hub_sync #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, sync_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      sync_q <= '0;
    end else begin
      meta_q <= d_i;
      sync_q <= meta_q;
    end
  end

  assign q_o = sync_q;
endmodule

// File: rtl/irq_hub_detect.sv
module irq_hub_detect #(
  parameter int unsigned W = 32
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] s_i,
  input  logic [W-1:0] pol_i,
  input  logic [W-1:0] trig_i,
  output logic [W-1:0] set_o
);
  logic [W-1:0] prev_q, active, edge_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_q <= '0;
    else         prev_q <= s_i;
  end

  // raw history, so a polarity change alone never looks like an edge
  assign active   = ~(s_i ^ pol_i);
  assign edge_hit = (s_i ^ prev_q) & active;
  assign set_o    = (trig_i & edge_hit) | (~trig_i & active);
endmodule

// File: rtl/irq_hub_prio.sv
module irq_hub_prio #(
  parameter int unsigned NSRC  = 32,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic [NSRC-1:0]  masked_i,
  output logic             valid_o,
  output logic [IDX_W-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int n = NSRC - 1; n >= 0; n--) begin
      if (masked_i[NSRC-1-n]) idx_o = IDX_W'(n);
    end
  end

  assign valid_o = |masked_i;
endmodule

// File: rtl/irq_hub.sv
module irq_hub #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NSRC-1:0]   src_i,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSRC-1:0]   wdata_i,
  output logic [NSRC-1:0]   rdata_o,
  output logic              irq_o,
  output logic              crit_o,
  output logic              pend_valid_o,
  output logic [IDX_W-1:0]  pend_idx_o
);
  import irq_hub_pkg::*;

  logic [NSRC-1:0] stat_q, en_q, route_q, pol_q, trig_q;
  logic [NSRC-1:0] s_src, pol_src, trig_src, set_src, set_w, masked;
  logic [WORD_W-1:0] word;
  logic wr;

  assign word = addr_i[ADDR_W-1:2];
  assign wr   = req_i & we_i;

  irq_hub_sync #(.W(NSRC)) u_sync (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(src_i), .q_o(s_src)
  );

  // source n <-> register bit NSRC-1-n
  for (genvar n = 0; n < NSRC; n++) begin : g_map
    assign pol_src[n]         = pol_q[NSRC-1-n];
    assign trig_src[n]        = trig_q[NSRC-1-n];
    assign set_w[NSRC-1-n]    = set_src[n];
  end

  irq_hub_detect #(.W(NSRC)) u_det (
    .clk_i(clk_i), .rst_ni(rst_ni), .s_i(s_src),
    .pol_i(pol_src), .trig_i(trig_src), .set_o(set_src)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stat_q  <= '0;
      en_q    <= '0;
      route_q <= '1;
      pol_q   <= '1;
      trig_q  <= '0;
    end else begin
      // new event wins over a same-cycle clear
      stat_q <= (stat_q & ~((wr && word == W_STAT) ? wdata_i : '0)) | set_w;
      if (wr && word == W_EN)    en_q    <= wdata_i;
      if (wr && word == W_ROUTE) route_q <= wdata_i;
      if (wr && word == W_POL)   pol_q   <= wdata_i;
      if (wr && word == W_TRIG)  trig_q  <= wdata_i;
    end
  end

  assign masked = stat_q & en_q;

  always_comb begin
    unique case (word)
      W_STAT:  rdata_o = stat_q;
      W_EN:    rdata_o = en_q;
      W_ROUTE: rdata_o = route_q;
      W_POL:   rdata_o = pol_q;
      W_TRIG:  rdata_o = trig_q;
      W_MASK:  rdata_o = masked;
      default: rdata_o = '0;
    endcase
  end

  assign irq_o  = |(masked & route_q);
  assign crit_o = |(masked & ~route_q);

  irq_hub_prio #(.NSRC(NSRC)) u_prio (
    .masked_i(masked), .valid_o(pend_valid_o), .idx_o(pend_idx_o)
  );
endmodule

// File: rtl/irq_hub_chk.sv
module irq_hub_chk #(
  parameter int unsigned NSRC   = 32,
  parameter int unsigned ADDR_W = 5,
  localparam int unsigned IDX_W = $clog2(NSRC)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              req_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [NSRC-1:0]   stat_q,
  input logic [NSRC-1:0]   en_q,
  input logic [NSRC-1:0]   set_w,
  input logic              irq_o,
  input logic              crit_o,
  input logic              pend_valid_o,
  input logic [IDX_W-1:0]  pend_idx_o
);
  logic [NSRC-1:0] msk;
  assign msk = stat_q & en_q;

  // R6: a status bit only rises when an event was detected
  assert_no_spurious_set_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((~$past(stat_q) & ~$past(set_w) & stat_q) == '0));

  // R10: reported index points at an enabled pending bit
  assert_idx_pending_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_o |-> msk[NSRC-1-int'(pend_idx_o)]);

  assert_valid_match_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pend_valid_o == (msk != '0));

  // R9: either request output implies something pending
  assert_irq_pending_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o || crit_o) |-> pend_valid_o);

  // R7: masked view is not writable
  assert_mask_ro_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_i && we_i && addr_i[ADDR_W-1:2] == 3'd5) |=> $stable(en_q));
endmodule

bind irq_hub irq_hub_chk #(.NSRC(NSRC), .ADDR_W(ADDR_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .we_i(we_i), .addr_i(addr_i),
  .stat_q(stat_q), .en_q(en_q), .set_w(set_w), .irq_o(irq_o), .crit_o(crit_o),
  .pend_valid_o(pend_valid_o), .pend_idx_o(pend_idx_o)
);

// File: tb/irq_hub_bench.sv
module irq_hub_bench;
  localparam int N = 32;
  localparam logic [4:0] A_STAT = 5'h00, A_EN = 5'h04, A_ROUTE = 5'h08,
                         A_POL = 5'h0C, A_TRIG = 5'h10, A_MASK = 5'h14;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [N-1:0] src = '0, wdata = '0, rdata;
  logic req = 1'b0, we = 1'b0;
  logic [4:0] addr = '0;
  logic irq, crit, pv;
  logic [4:0] pidx;
  int checks = 0, errors = 0;

  always #4 clk = ~clk;

  irq_hub u_irq_hub (
    .clk_i(clk), .rst_ni(rst_n), .src_i(src), .req_i(req), .we_i(we),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq),
    .crit_o(crit), .pend_valid_o(pv), .pend_idx_o(pidx)
  );

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [4:0] a, logic [31:0] d);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk); req = 1'b0; we = 1'b0;
  endtask

  task automatic rd(logic [4:0] a, output logic [31:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [31:0] bitof(int n);
    return 32'h1 << (31 - n);
  endfunction

  initial begin
    #(200000 * 8);
    checks++; errors++;
    $display("FAIL watchdog act=%h exp=%h", 0, 1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [31:0] v, exp_m, en;
    int exp_i;
    idle(2); rst_n = 1'b1; idle(1);
    // R1 reset state
    rd(A_STAT, v);  check("R1 stat", v, 32'h0);
    rd(A_EN, v);    check("R1 en", v, 32'h0);
    rd(A_ROUTE, v); check("R1 route", v, 32'hFFFF_FFFF);
    rd(A_POL, v);   check("R1 pol", v, 32'hFFFF_FFFF);
    rd(A_TRIG, v);  check("R1 trig", v, 32'h0);
    check("R1 outs", {29'd0, irq, crit, pv}, 32'h0);

    // R2 R3 R4 R5 R6 sweep per source and mode
    for (int n = 0; n < N; n++) begin
      for (int m = 0; m < 4; m++) begin
        logic pol, trg;
        pol = m[0]; trg = m[1];
        wr(A_POL, pol ? 32'hFFFF_FFFF : 32'h0);
        wr(A_TRIG, trg ? 32'hFFFF_FFFF : 32'h0);
        wr(A_EN, bitof(n));
        src = pol ? '0 : '1;
        idle(5); wr(A_STAT, 32'hFFFF_FFFF); idle(1);
        rd(A_STAT, v); check("R3 idle no set", v, 32'h0);
        src[n] = pol;
        idle(4);
        rd(A_STAT, v); check("R2 status bit", v, bitof(n));
        rd(A_MASK, v); check("R7 masked", v, bitof(n));
        check("R10 idx", {26'd0, pv, pidx}, {26'd0, 1'b1, 5'(n)});
        check("R9 irq", {30'd0, irq, crit}, 32'h2);
        src[n] = ~pol; idle(4);
        rd(A_STAT, v); check(trg ? "R5 held after release" : "R4 latched", v, bitof(n));
        wr(A_STAT, bitof(n));
        rd(A_STAT, v); check("R6 w1c", v, 32'h0);
        src[n] = pol; idle(4);
        wr(A_STAT, bitof(n)); idle(1);
        rd(A_STAT, v);
        if (trg) check("R5 clear while held", v, 32'h0);
        else     check("R4 clear while active", v, bitof(n));
        src[n] = ~pol; idle(4); wr(A_STAT, 32'hFFFF_FFFF);
      end
    end

    // R10 R8 priority sweep, level active-high
    wr(A_POL, 32'hFFFF_FFFF); wr(A_TRIG, 32'h0);
    src = '0; idle(5); wr(A_STAT, 32'hFFFF_FFFF);
    for (int k = 0; k < N; k++) begin
      logic [31:0] pat;
      pat = 32'h0; pat[k] = 1'b1;
      for (int j = k + 1; j < N; j++) if (j % 3 == 0) pat[j] = 1'b1;
      wr(A_EN, 32'hFFFF_FFFF);
      src = pat; idle(4);
      exp_m = 32'h0;
      for (int j = 0; j < N; j++) if (pat[j]) exp_m |= bitof(j);
      rd(A_MASK, v); check("R7 masked pattern", v, exp_m);
      check("R10 lowest wins", {26'd0, pv, pidx}, {26'd0, 1'b1, 5'(k)});
      en = 32'hFFFF_FFFF & ~bitof(k);
      wr(A_EN, en); idle(1);
      exp_i = -1;
      for (int j = N - 1; j > k; j--) if (pat[j]) exp_i = j;
      if (exp_i < 0) check("R8 none pending", {30'd0, pv, irq}, 32'h0);
      else check("R8 next wins", {26'd0, pv, pidx}, {26'd0, 1'b1, 5'(exp_i)});
      rd(A_STAT, v); check("R8 status kept", v, exp_m);
      src = '0; idle(4); wr(A_STAT, 32'hFFFF_FFFF);
    end

    // R9 routing
    wr(A_EN, 32'hFFFF_FFFF); wr(A_ROUTE, ~bitof(5));
    src[5] = 1'b1; idle(4);
    check("R9 crit only", {30'd0, irq, crit}, 32'h1);
    src[9] = 1'b1; idle(4);
    check("R9 both", {30'd0, irq, crit}, 32'h3);
    wr(A_EN, ~bitof(5)); idle(1);
    check("R9 normal only", {30'd0, irq, crit}, 32'h2);

    // R7 masked write ignored, R11 unmapped
    wr(A_MASK, 32'h0);
    rd(A_EN, v); check("R7 en untouched", v, ~bitof(5));
    rd(A_MASK, v); check("R7 mask untouched", v, bitof(9));
    rd(A_ROUTE, v); check("R11 route offset", v, ~bitof(5));
    rd(5'h18, v); check("R11 unmapped 18", v, 32'h0);
    rd(5'h1C, v); check("R11 unmapped 1c", v, 32'h0);
    src = '0; idle(4); wr(A_ROUTE, 32'hFFFF_FFFF);

    // R6 edge and clear in the same cycle
    wr(A_TRIG, 32'hFFFF_FFFF); wr(A_EN, bitof(3));
    idle(4); wr(A_STAT, 32'hFFFF_FFFF);
    src[3] = 1'b1; idle(4); src[3] = 1'b0; idle(4);
    rd(A_STAT, v); check("R6 edge latched", v, bitof(3));
    @(negedge clk); src[3] = 1'b1;
    @(posedge clk); @(posedge clk);
    @(negedge clk); req = 1'b1; we = 1'b1; addr = A_STAT; wdata = bitof(3);
    @(negedge clk); req = 1'b0; we = 1'b0;
    rd(A_STAT, v); check("R6 set beats clear", v, bitof(3));
    wr(A_STAT, bitof(3));
    rd(A_STAT, v); check("R6 later clear", v, 32'h0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule